// File: doc/BRIEF.md
# Change-Event Recorder with Timestamps

This block watches a small group of slow digital inputs, such as buttons, switches and header pins, on a sample-rate clock. During a recording session it writes a record into a write FIFO on the memory side, but only in sample periods where at least one input has changed. Each record joins a free-running timestamp with the current input states. The stored data is therefore a compact list of edges, and each edge carries its time, in place of a copy of every sample.

A session runs while record mode is requested and playback is not, and only once the clock generator reports lock and the memory interface reports calibration done. A status output shows when a session is live. The timestamp starts at zero at the beginning of each session and wraps around when it reaches its width. The first sample of a session always produces a record, so later edges have a known starting state. An event that arrives while the FIFO reports full is dropped and sets a sticky overflow flag.

Top module: `event_recorder`

## Requirements
- R1: A record word has the timestamp in its upper TS_W bits and the synchronised input states in its lower DATA_W bits. The defaults are 25 and 7, which gives a 32-bit word.
- R2: Within a session, the timestamp of the first sample cycle is 0 and rises by one each sample cycle, modulo 2^TS_W.
- R3: A change on `pins_in` is seen after SYNC_STAGES (2) sample clocks. When the synchronised value differs from the previous cycle's value, `fifo_wr` is high for exactly one cycle, after the third rising edge that follows the input change. No write occurs for cycles in which nothing changed.
- R4: The first sample cycle of every session produces a record whatever the input history is. This baseline carries timestamp 0.
- R5: `rec_active` goes high on the edge after `rec_req`, `pll_locked` and `mem_calib_done` are all high while `play_req` is low. It goes low on the edge after any of these conditions stops holding.
- R6: `fifo_wr` is never high for a sample cycle in which the session was not active. This covers playback mode.
- R7: An event that meets `fifo_full` high produces no write and sets `overflow`. `overflow` stays high until the next session starts or reset is applied.
- R8: While `rst` is high, and on the edge after it, `rec_active`, `fifo_wr` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_req | input | 1 | Record mode requested |
| play_req | input | 1 | Playback mode requested; blocks recording |
| pll_locked | input | 1 | Clock generator lock indication |
| mem_calib_done | input | 1 | Memory interface calibration complete |
| pins_in | input | DATA_W (7) | Asynchronous monitored inputs |
| fifo_full | input | 1 | Write FIFO full |
| fifo_wr | output | 1 | Write strobe for the FIFO |
| fifo_wdata | output | TS_W+DATA_W (32) | Record: timestamp and input states |
| rec_active | output | 1 | Recording session live |
| overflow | output | 1 | Sticky dropped-event flag |

## Verification
The status output is due one edge after its permit inputs change. A record is due three edges after a pin change: two synchroniser edges and the output register. The baseline record is due two edges after the permit inputs become true. The bench stores the inputs it applied at every rising edge and samples the outputs at the following falling edge. Each expectation is built from the stored values at the offsets listed above, so every check looks at exactly the cycle in which its result is due.

// File: rtl/rec_pkg.sv
package rec_pkg;

    localparam int DEF_TS_W   = 25;
    localparam int DEF_DATA_W = 7;
    localparam int DEF_SYNC   = 2;

    typedef enum logic {
        SES_IDLE = 1'b0,
        SES_RUN  = 1'b1
    } ses_state_e;

    // Session flags handed from the session controller to the datapath.
    typedef struct packed {
        logic run;    // session live in this sample cycle
        logic start;  // first sample cycle of a session
    } ses_flags_t;

    // Per-cycle event decision inside the datapath.
    typedef struct packed {
        logic event_hit;  // record wanted this cycle
        logic drop;       // record wanted but FIFO full
        logic store;      // record written
    } evt_dec_t;

    function automatic logic session_permit(
        input logic req,
        input logic play,
        input logic locked,
        input logic calib
    );
        return req & ~play & locked & calib;
    endfunction

endpackage

// File: rtl/rec_sync.sv
module rec_sync #(
    parameter int W      = rec_pkg::DEF_DATA_W,
    parameter int STAGES = rec_pkg::DEF_SYNC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[LAST];
endmodule

// File: rtl/rec_session.sv
module rec_session
    import rec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rec_req,
    input  logic       play_req,
    input  logic       pll_locked,
    input  logic       mem_calib_done,
    output ses_flags_t flags
);
    ses_state_e state_q;
    logic       ran_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SES_IDLE;
            ran_q   <= 1'b0;
        end else begin
            state_q <= session_permit(rec_req, play_req, pll_locked, mem_calib_done)
                       ? SES_RUN : SES_IDLE;
            ran_q   <= (state_q == SES_RUN);
        end
    end

    always_comb begin
        flags.run   = (state_q == SES_RUN);
        flags.start = (state_q == SES_RUN) && !ran_q;
    end
endmodule

// File: rtl/rec_stamp.sv
module rec_stamp
    import rec_pkg::*;
#(
    parameter int TS_W = DEF_TS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  ses_flags_t      flags,
    output logic [TS_W-1:0] stamp
);
    localparam logic [TS_W-1:0] STEP = TS_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !flags.run) stamp <= '0;
        else                   stamp <= stamp + STEP;
    end
endmodule

// File: rtl/rec_event.sv
module rec_event
    import rec_pkg::*;
#(
    parameter int TS_W   = DEF_TS_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  ses_flags_t             flags,
    input  logic [TS_W-1:0]        stamp,
    input  logic [DATA_W-1:0]      pins_s,
    input  logic                   fifo_full,
    output logic                   fifo_wr,
    output logic [TS_W+DATA_W-1:0] fifo_wdata,
    output logic                   overflow
);
    localparam int REC_W = TS_W + DATA_W;

    logic [DATA_W-1:0] last_q;
    logic              changed;
    evt_dec_t          dec;
    logic [REC_W-1:0]  rec_word;

    assign changed  = (pins_s != last_q);
    assign rec_word = {stamp, pins_s};

    always_comb begin
        dec.event_hit = flags.run && (flags.start || changed);
        dec.drop      = dec.event_hit && fifo_full;
        dec.store     = dec.event_hit && !fifo_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q     <= '0;
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
            overflow   <= 1'b0;
        end else begin
            last_q  <= pins_s;
            fifo_wr <= dec.store;
            if (dec.store) fifo_wdata <= rec_word;
            if (flags.start) overflow <= dec.drop;
            else if (dec.drop) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/event_recorder.sv
module event_recorder
    import rec_pkg::*;
#(
    parameter int TS_W   = DEF_TS_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int SYNC   = DEF_SYNC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rec_req,
    input  logic                   play_req,
    input  logic                   pll_locked,
    input  logic                   mem_calib_done,
    input  logic [DATA_W-1:0]      pins_in,
    input  logic                   fifo_full,
    output logic                   fifo_wr,
    output logic [TS_W+DATA_W-1:0] fifo_wdata,
    output logic                   rec_active,
    output logic                   overflow
);
    ses_flags_t        flags;
    logic [TS_W-1:0]   stamp;
    logic [DATA_W-1:0] pins_s;

    rec_sync #(.W(DATA_W), .STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_in),
        .dout (pins_s)
    );

    rec_session u_session (
        .clk            (clk),
        .rst            (rst),
        .rec_req        (rec_req),
        .play_req       (play_req),
        .pll_locked     (pll_locked),
        .mem_calib_done (mem_calib_done),
        .flags          (flags)
    );

    rec_stamp #(.TS_W(TS_W)) u_stamp (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .stamp (stamp)
    );

    rec_event #(.TS_W(TS_W), .DATA_W(DATA_W)) u_event (
        .clk        (clk),
        .rst        (rst),
        .flags      (flags),
        .stamp      (stamp),
        .pins_s     (pins_s),
        .fifo_full  (fifo_full),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .overflow   (overflow)
    );

    assign rec_active = flags.run;
endmodule

// File: rtl/rec_checker.sv
module rec_checker #(
    parameter int TS_W   = 25,
    parameter int DATA_W = 7
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rec_req,
    input logic                   play_req,
    input logic                   pll_locked,
    input logic                   mem_calib_done,
    input logic                   fifo_full,
    input logic                   fifo_wr,
    input logic [TS_W+DATA_W-1:0] fifo_wdata,
    input logic                   rec_active,
    input logic                   overflow
);
    localparam int REC_W = TS_W + DATA_W;

    logic [TS_W-1:0] ts_now;
    assign ts_now = fifo_wdata[REC_W-1:DATA_W];

    AST_ACTIVE_PERMIT: assert property (@(posedge clk) disable iff (rst)
        rec_active |-> $past(rec_req && !play_req && pll_locked && mem_calib_done)); // R5

    AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(rec_active)); // R6

    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !$past(fifo_full)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && rec_active && $past(rec_active)) |=> overflow); // R7

    AST_BASELINE: assert property (@(posedge clk) disable iff (rst)
        ($past(rec_active) && !$past(rec_active, 2)) |-> (fifo_wr || overflow)); // R4

    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && $past(fifo_wr)) |-> (ts_now == $past(ts_now) + TS_W'(1))); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!rec_active && !fifo_wr && !overflow)); // R8
endmodule

bind event_recorder rec_checker #(.TS_W(TS_W), .DATA_W(DATA_W)) u_rec_checker (
    .clk            (clk),
    .rst            (rst),
    .rec_req        (rec_req),
    .play_req       (play_req),
    .pll_locked     (pll_locked),
    .mem_calib_done (mem_calib_done),
    .fifo_full      (fifo_full),
    .fifo_wr        (fifo_wr),
    .fifo_wdata     (fifo_wdata),
    .rec_active     (rec_active),
    .overflow       (overflow)
);

// File: tb/test_event_recorder.sv
`timescale 1ns/1ps
module test_event_recorder;
    localparam int TS_W   = 5;
    localparam int DATA_W = 7;
    localparam int REC_W  = TS_W + DATA_W;
    localparam int HMAX   = 4096;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rec_req = 1'b0, play_req = 1'b0;
    logic              pll_locked = 1'b0, mem_calib_done = 1'b0;
    logic [DATA_W-1:0] pins_in = '0;
    logic              fifo_full = 1'b0;
    logic              fifo_wr, rec_active, overflow;
    logic [REC_W-1:0]  fifo_wdata;

    always #4 clk = ~clk;

    event_recorder #(.TS_W(TS_W), .DATA_W(DATA_W), .SYNC(2)) i_event_recorder (
        .clk(clk), .rst(rst), .rec_req(rec_req), .play_req(play_req),
        .pll_locked(pll_locked), .mem_calib_done(mem_calib_done),
        .pins_in(pins_in), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .rec_active(rec_active), .overflow(overflow)
    );

    int checks = 0, failures = 0, cyc = 0;

    logic              h_rst [HMAX];
    logic              h_perm[HMAX];
    logic              h_full[HMAX];
    logic [DATA_W-1:0] h_pin [HMAX];
    logic              e_act [HMAX];
    logic [TS_W-1:0]   e_ts  [HMAX];
    logic              e_ovf [HMAX];

    initial begin
        for (int i = 0; i < HMAX; i++) begin
            h_rst[i] = 1'b1; h_perm[i] = 1'b0; h_full[i] = 1'b0; h_pin[i] = '0;
            e_act[i] = 1'b0; e_ts[i] = '0; e_ovf[i] = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (cyc < HMAX - 1) begin
            cyc = cyc + 1;
            h_rst[cyc]  = rst;
            h_perm[cyc] = rec_req & ~play_req & pll_locked & mem_calib_done;
            h_full[cyc] = fifo_full;
            h_pin[cyc]  = pins_in;
        end
    end

    task automatic chk(input string tag, input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Expected values for the outputs settled after rising edge n.
    always @(negedge clk) begin
        int n;
        logic act1, first, chg, ev, ewr;
        string tg;
        n = cyc;
        if (n >= 3) begin
            e_act[n] = h_rst[n] ? 1'b0 : h_perm[n];
            e_ts[n]  = (h_rst[n] || !e_act[n-1]) ? '0 : e_ts[n-1] + TS_W'(1);
            act1  = h_rst[n] ? 1'b0 : e_act[n-1];
            first = act1 && !e_act[n-2];
            chg   = (h_pin[n-2] != h_pin[n-3]);
            ev    = act1 && (first || chg);
            ewr   = ev && !h_full[n];
            e_ovf[n] = h_rst[n] ? 1'b0 : (first ? (ev && h_full[n]) : (e_ovf[n-1] || (ev && h_full[n])));
            chk(h_rst[n] ? "R8 active" : "R5 active", REC_W'(rec_active), REC_W'(e_act[n]));
            if (h_rst[n])                 tg = "R8 write";
            else if (first)               tg = "R4 baseline write";
            else if (ev && h_full[n])     tg = "R7 dropped write";
            else if (!act1)               tg = "R6 idle write";
            else                          tg = "R3 change write";
            chk(tg, REC_W'(fifo_wr), REC_W'(ewr));
            if (ewr) chk("R1 R2 record", fifo_wdata, {e_ts[n-1], h_pin[n-2]});
            chk(h_rst[n] ? "R8 overflow" : "R7 overflow", REC_W'(overflow), REC_W'(e_ovf[n]));
        end
    end

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    logic done = 1'b0;

    initial begin
        step(5);
        rst = 1'b0;
        step(3);
        // R5: permit needs every condition
        rec_req = 1'b1; step(3);
        pll_locked = 1'b1; step(3);
        mem_calib_done = 1'b1; step(4);
        // R3 sweep: every input value, one cycle each (wraps the stamp, R2)
        for (int v = 0; v < 128; v++) begin pins_in = DATA_W'(v); step(1); end
        // holding steady: no writes
        step(6);
        // single-bit toggles with varying hold lengths
        for (int b = 0; b < DATA_W; b++) begin
            pins_in = pins_in ^ DATA_W'(1 << b); step(1 + (b % 3));
        end
        // R6: playback ends the session, changes ignored
        play_req = 1'b1; step(2);
        for (int v = 0; v < 10; v++) begin pins_in = DATA_W'(v * 13); step(1); end
        step(3);
        // R4: new session, baseline even with no change
        play_req = 1'b0; step(6);
        // R7: full FIFO while events occur
        fifo_full = 1'b1;
        for (int v = 0; v < 4; v++) begin pins_in = pins_in + 7'd3; step(2); end
        fifo_full = 1'b0; step(4);
        pins_in = 7'h55; step(4);
        // overflow survives losing calibration until a new session
        mem_calib_done = 1'b0; step(3);
        fifo_full = 1'b1; mem_calib_done = 1'b1; step(1);
        fifo_full = 1'b0; step(4);
        // restart clears overflow
        rec_req = 1'b0; step(2);
        rec_req = 1'b1; step(3);
        // long sweep with gray sequence, stamp wrap again
        for (int v = 0; v < 80; v++) begin pins_in = DATA_W'(v ^ (v >> 1)); step(1 + (v % 2)); end
        step(5);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule